// File: doc/BRIEF.md
# Chunked Page-Cache Load Sequencer for Serial NAND

This block fills the page cache of a serial NAND flash device. The bus controller that carries the traffic can move only a limited number of bytes while chip select stays low. The block therefore splits a page into a series of separate transactions. Every transaction begins with a one-byte command and a three-byte column address, and data bytes follow. Software provides a page length, picks single-line or four-line data transfer and pulses `start`. Page bytes then arrive on a valid/ready stream. The block ends each transaction by raising `csN` and reports the whole page with a one-cycle `done` pulse.

Only the first transaction of a page uses the command that wipes the cache before it writes. Every later transaction uses the command that writes at a column and keeps the other cache bytes. The column address of each transaction continues from the point where the previous one stopped. The serial clock runs in SPI mode 0. It comes from the system clock through a divider that can be set at run time. It is stopped, not stretched, when the data stream stalls.

Top module: `cache_load_seq`

## Requirements
- R1: After reset, `csN` is 1, `sclk` is 0, `done` is 0 and `inReady` is 0.
- R2: A page of L bytes goes out as ceil(L/1020) transactions. Each transaction carries min(remaining, 1020) data bytes, so a limit of 1024 bytes per transaction includes the 4 header bytes. For example, 2112 bytes go out as 1020, 1020 and 72.
- R3: The first transaction of a page carries command 0x32 when `quadSel` was 1 at start, and 0x02 when it was 0.
- R4: Every later transaction of the same page carries command 0x34 in four-line mode and 0x84 in single-line mode.
- R5: The command byte is followed by a 24-bit column address, sent most significant byte first. The address equals the number of page bytes already sent in earlier transactions of the page.
- R6: The command and the address go out on `io[0]` only, most significant bit first. Data bytes go out on `io[0]` most significant bit first in single-line mode. In four-line mode they go out on `io[3:0]`, with the high nibble first. Each bit is valid at a rising edge of `sclk`.
- R7: `sclk` is low whenever `csN` is high, and it is low at every edge of `csN`.
- R8: Between two transactions `csN` stays high for at least 4*(`halfDiv`+1) system clock cycles, which is two serial clock periods.
- R9: `done` is a one-cycle pulse, given once per page after `csN` has risen at the end of the last transaction.
- R10: When `inValid` is low, no `sclk` edge occurs while a data byte is awaited and `csN` stays low. Exactly L bytes are taken from the stream, and they arrive in the cache in order. `inReady` is high only while `csN` is low.
- R11: A start with a page length of 0 gives `done` within 3 cycles, and `csN` never goes low.
- R12: A `start` pulse during a page has no effect on the page. A change of `pageLen` or `quadSel` during a page also has no effect.
- R13: Each high phase of `sclk` lasts exactly `halfDiv`+1 system clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin loading one page (sampled only when idle) |
| pageLen | input | LEN_W | Page length in bytes |
| quadSel | input | 1 | 1 = four-line data, 0 = single-line |
| halfDiv | input | DIV_W | Serial clock half period minus one, in system clocks |
| inData | input | 8 | Page byte stream |
| inValid | input | 1 | `inData` holds a byte |
| inReady | output | 1 | Block accepts a byte this cycle |
| sclk | output | 1 | Serial clock |
| csN | output | 1 | Active-low chip select |
| io | output | 4 | Serial data lines |
| done | output | 1 | One-cycle pulse when the page is loaded |

## Verification
A wrong first-transaction flag or a wrong column counter shows at the ports in the next header, which is at most 1024 bytes of serial traffic later. It appears either as a wrong command byte or as a wrong address. A bench-side cache model also turns the flag error into lost page bytes. A slipped bit or byte counter shifts every later data bit on the lines. It can also end a transaction early, so the transaction sizes and the bytes drawn from the stream disagree with the page length by the time `done` appears. Divider, gap and stall faults appear within a single serial clock period, as a wrong high time, a short chip-select gap or an `sclk` edge while a byte is awaited.

// File: rtl/cache_load_pkg.sv
`timescale 1ns/1ps
package cache_load_pkg;
  // Command bytes: cache-clearing load and cache-preserving random load
  localparam logic [7:0] OP_LOAD_X1 = 8'h02;
  localparam logic [7:0] OP_LOAD_X4 = 8'h32;
  localparam logic [7:0] OP_RAND_X1 = 8'h84;
  localparam logic [7:0] OP_RAND_X4 = 8'h34;

  // Strobes from control to datapath
  typedef struct packed {
    logic latchPage;   // capture page length, clear column
    logic beginChunk;  // size the chunk and pull chip select low
    logic loadHdr;     // load a header byte into the shifter
    logic loadData;    // load a stream byte into the shifter
    logic rise;        // serial clock rising edge
    logic fall;        // serial clock falling edge and shift
    logic csRelease;   // end chunk, advance column and remainder
  } strobe_t;

  typedef enum logic [1:0] {ST_IDLE, ST_LAUNCH, ST_XFER, ST_GAP} seqState_t;
endpackage

// File: rtl/cache_load_dp.sv
`timescale 1ns/1ps
module cache_load_dp
  import cache_load_pkg::*;
#(
  parameter int LEN_W      = 12,
  parameter int DIV_W      = 8,
  parameter int MAX_XFER   = 1024,
  parameter int ADDR_BYTES = 3,
  localparam int HDR_BYTES = ADDR_BYTES + 1,
  localparam int CNT_W     = $clog2(MAX_XFER + 1),
  localparam int HS_W      = $clog2(HDR_BYTES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic [HS_W-1:0]  hdrSel,
  input  logic             quadData,
  input  logic             firstChunk,
  input  logic             quadMode,
  input  logic [LEN_W-1:0] pageLen,
  input  logic [DIV_W-1:0] halfDiv,
  input  logic [7:0]       inData,
  output logic             tick,
  output logic             remZero,
  output logic [CNT_W-1:0] chunkTotal,
  output logic             sclk,
  output logic             csN,
  output logic [3:0]       io
);
  localparam int MAX_DATA = MAX_XFER - HDR_BYTES;
  localparam int COL_W    = 8 * ADDR_BYTES;

  logic [DIV_W-1:0] divCnt;
  logic [LEN_W-1:0] remaining;
  logic [LEN_W-1:0] chunkNext;
  logic [COL_W-1:0] column;
  logic [CNT_W-1:0] chunkLen;
  logic [7:0]       shReg;
  logic [7:0]       opcode;
  logic [7:0]       hdrBytes [HDR_BYTES];
  logic             sclkQ;
  logic             csQ;

  // Half-period tick from the free-running divider
  assign tick = (divCnt >= halfDiv);
  always_ff @(posedge clk) begin
    if (!rstN)     divCnt <= '0;
    else if (tick) divCnt <= '0;
    else           divCnt <= divCnt + 1'b1;
  end

  assign chunkNext  = (remaining > LEN_W'(MAX_DATA)) ? LEN_W'(MAX_DATA) : remaining;
  assign chunkTotal = chunkLen + CNT_W'(HDR_BYTES);
  assign remZero    = (remaining == '0);

  always_comb begin
    if (firstChunk) opcode = quadMode ? OP_LOAD_X4 : OP_LOAD_X1;
    else            opcode = quadMode ? OP_RAND_X4 : OP_RAND_X1;
  end

  // Header bytes: command, then the column address high byte first
  assign hdrBytes[0] = opcode;
  for (genvar gi = 1; gi <= ADDR_BYTES; gi++) begin : g_addrByte
    assign hdrBytes[gi] = column[COL_W - 8*gi +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remaining <= '0;
      column    <= '0;
      chunkLen  <= '0;
      shReg     <= '0;
      sclkQ     <= 1'b0;
      csQ       <= 1'b1;
    end else begin
      if (stb.latchPage) begin
        remaining <= pageLen;
        column    <= '0;
      end
      if (stb.beginChunk) begin
        chunkLen <= CNT_W'(chunkNext);
        csQ      <= 1'b0;
      end
      if (stb.loadHdr)       shReg <= hdrBytes[hdrSel];
      else if (stb.loadData) shReg <= inData;
      else if (stb.fall)     shReg <= quadData ? {shReg[3:0], 4'h0} : {shReg[6:0], 1'b0};
      if (stb.rise) sclkQ <= 1'b1;
      if (stb.fall) sclkQ <= 1'b0;
      if (stb.csRelease) begin
        csQ       <= 1'b1;
        remaining <= remaining - LEN_W'(chunkLen);
        column    <= column + COL_W'(chunkLen);
      end
    end
  end

  assign sclk = sclkQ;
  assign csN  = csQ;
  assign io   = quadData ? shReg[7:4] : {3'b000, shReg[7]};
endmodule

// File: rtl/cache_load_ctrl.sv
`timescale 1ns/1ps
module cache_load_ctrl
  import cache_load_pkg::*;
#(
  parameter int LEN_W      = 12,
  parameter int MAX_XFER   = 1024,
  parameter int ADDR_BYTES = 3,
  parameter int GAP_SCLKS  = 2,
  localparam int HDR_BYTES = ADDR_BYTES + 1,
  localparam int CNT_W     = $clog2(MAX_XFER + 1),
  localparam int HS_W      = $clog2(HDR_BYTES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [LEN_W-1:0] pageLen,
  input  logic             quadSel,
  input  logic             inValid,
  input  logic             tick,
  input  logic             remZero,
  input  logic [CNT_W-1:0] chunkTotal,
  output strobe_t          stb,
  output logic [HS_W-1:0]  hdrSel,
  output logic             quadData,
  output logic             firstChunk,
  output logic             quadMode,
  output logic             inReady,
  output logic             done
);
  localparam int GAP_TICKS = 2 * GAP_SCLKS;
  localparam int GAP_W     = $clog2(GAP_TICKS);

  seqState_t        state;
  logic [CNT_W-1:0] byteIdx;
  logic [CNT_W-1:0] nextIdx;
  logic [2:0]       bitCnt;
  logic [GAP_W-1:0] gapCnt;
  logic             loaded;
  logic             phase;
  logic             firstReg;
  logic             quadReg;
  logic             doneReg;
  logic             lastUnit;
  logic             lastByte;
  logic             edgeOk;

  assign nextIdx  = byteIdx + 1'b1;
  assign quadData = (state == ST_XFER) && quadReg && (byteIdx >= CNT_W'(HDR_BYTES));
  assign lastUnit = quadData ? (bitCnt == 3'd1) : (bitCnt == 3'd7);
  assign lastByte = (byteIdx == chunkTotal - 1'b1);
  assign edgeOk   = (state == ST_XFER) && loaded && tick;
  assign hdrSel   = (state == ST_XFER) ? nextIdx[HS_W-1:0] : '0;

  always_comb begin
    stb            = '0;
    stb.latchPage  = (state == ST_IDLE) && start && (pageLen != '0);
    stb.beginChunk = (state == ST_LAUNCH);
    stb.rise       = edgeOk && !phase;
    stb.fall       = edgeOk && phase;
    stb.loadHdr    = (state == ST_LAUNCH) ||
                     (stb.fall && lastUnit && !lastByte && (nextIdx < CNT_W'(HDR_BYTES)));
    stb.loadData   = (state == ST_XFER) && !loaded && inValid;
    stb.csRelease  = stb.fall && lastUnit && lastByte;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      byteIdx  <= '0;
      bitCnt   <= '0;
      gapCnt   <= '0;
      loaded   <= 1'b0;
      phase    <= 1'b0;
      firstReg <= 1'b0;
      quadReg  <= 1'b0;
      doneReg  <= 1'b0;
    end else begin
      doneReg <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          if (pageLen == '0) doneReg <= 1'b1;
          else begin
            quadReg  <= quadSel;
            firstReg <= 1'b1;
            state    <= ST_LAUNCH;
          end
        end
        ST_LAUNCH: begin
          state   <= ST_XFER;
          loaded  <= 1'b1;
          byteIdx <= '0;
          bitCnt  <= '0;
          phase   <= 1'b0;
        end
        ST_XFER: begin
          if (!loaded) begin
            if (inValid) loaded <= 1'b1;
          end else if (tick) begin
            if (!phase) phase <= 1'b1;
            else begin
              phase <= 1'b0;
              if (!lastUnit) bitCnt <= bitCnt + 1'b1;
              else begin
                bitCnt <= '0;
                if (lastByte) begin
                  state    <= ST_GAP;
                  gapCnt   <= '0;
                  firstReg <= 1'b0;
                end else begin
                  byteIdx <= nextIdx;
                  if (nextIdx >= CNT_W'(HDR_BYTES)) loaded <= 1'b0;
                end
              end
            end
          end
        end
        ST_GAP: if (tick) begin
          if (gapCnt == GAP_W'(GAP_TICKS - 1)) begin
            if (remZero) begin
              doneReg <= 1'b1;
              state   <= ST_IDLE;
            end else state <= ST_LAUNCH;
          end else gapCnt <= gapCnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign firstChunk = firstReg;
  assign quadMode   = quadReg;
  assign inReady    = (state == ST_XFER) && !loaded;
  assign done       = doneReg;
endmodule

// File: rtl/cache_load_seq.sv
`timescale 1ns/1ps
module cache_load_seq
  import cache_load_pkg::*;
#(
  parameter int LEN_W      = 12,
  parameter int DIV_W      = 8,
  parameter int MAX_XFER   = 1024,
  parameter int ADDR_BYTES = 3,
  parameter int GAP_SCLKS  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [LEN_W-1:0] pageLen,
  input  logic             quadSel,
  input  logic [DIV_W-1:0] halfDiv,
  input  logic [7:0]       inData,
  input  logic             inValid,
  output logic             inReady,
  output logic             sclk,
  output logic             csN,
  output logic [3:0]       io,
  output logic             done
);
  localparam int HDR_BYTES = ADDR_BYTES + 1;
  localparam int CNT_W     = $clog2(MAX_XFER + 1);
  localparam int HS_W      = $clog2(HDR_BYTES);

  strobe_t          stb;
  logic [HS_W-1:0]  hdrSel;
  logic [CNT_W-1:0] chunkTotal;
  logic             quadData;
  logic             firstChunk;
  logic             quadMode;
  logic             tick;
  logic             remZero;

  cache_load_ctrl #(
    .LEN_W(LEN_W), .MAX_XFER(MAX_XFER), .ADDR_BYTES(ADDR_BYTES), .GAP_SCLKS(GAP_SCLKS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .pageLen(pageLen), .quadSel(quadSel),
    .inValid(inValid), .tick(tick), .remZero(remZero), .chunkTotal(chunkTotal),
    .stb(stb), .hdrSel(hdrSel), .quadData(quadData), .firstChunk(firstChunk),
    .quadMode(quadMode), .inReady(inReady), .done(done)
  );

  cache_load_dp #(
    .LEN_W(LEN_W), .DIV_W(DIV_W), .MAX_XFER(MAX_XFER), .ADDR_BYTES(ADDR_BYTES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .hdrSel(hdrSel), .quadData(quadData),
    .firstChunk(firstChunk), .quadMode(quadMode), .pageLen(pageLen), .halfDiv(halfDiv),
    .inData(inData), .tick(tick), .remZero(remZero), .chunkTotal(chunkTotal),
    .sclk(sclk), .csN(csN), .io(io)
  );
endmodule

// File: rtl/cache_load_chk.sv
`timescale 1ns/1ps
module cache_load_chk #(
  parameter int DIV_W     = 8,
  parameter int GAP_SCLKS = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             csN,
  input logic             sclk,
  input logic             done,
  input logic             inReady,
  input logic [DIV_W-1:0] halfDiv
);
  logic [15:0] highCnt;
  logic [15:0] sclkHiCnt;
  logic [15:0] gapNeed;

  assign gapNeed = (16'(halfDiv) + 16'd1) * 16'(2 * GAP_SCLKS);

  // Cycles with csN high (saturating, starts full so reset counts as idle)
  always_ff @(posedge clk) begin
    if (!rstN)                highCnt <= '1;
    else if (!csN)            highCnt <= '0;
    else if (highCnt != '1)   highCnt <= highCnt + 16'd1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)      sclkHiCnt <= '0;
    else if (!sclk) sclkHiCnt <= '0;
    else            sclkHiCnt <= sclkHiCnt + 16'd1;
  end

  AST_SCLK_IDLE_LOW:    assert property (@(posedge clk) disable iff (!rstN) csN |-> !sclk);                   // R7
  AST_CS_FALL_SCLK_LOW: assert property (@(posedge clk) disable iff (!rstN) $fell(csN) |-> !sclk);            // R7
  AST_CS_GAP:           assert property (@(posedge clk) disable iff (!rstN) $fell(csN) |-> (highCnt >= gapNeed)); // R8
  AST_DONE_SINGLE:      assert property (@(posedge clk) disable iff (!rstN) done |=> !done);                  // R9
  AST_DONE_CS_HIGH:     assert property (@(posedge clk) disable iff (!rstN) done |-> csN);                    // R9
  AST_READY_IN_XFER:    assert property (@(posedge clk) disable iff (!rstN) inReady |-> !csN);                // R10
  AST_STALL_HOLD:       assert property (@(posedge clk) disable iff (!rstN) inReady |-> !sclk);               // R10
  AST_SCLK_HIGH_TIME:   assert property (@(posedge clk) disable iff (!rstN)
                                         $fell(sclk) |-> (sclkHiCnt == 16'(halfDiv) + 16'd1));             // R13
endmodule

bind cache_load_seq cache_load_chk #(.DIV_W(DIV_W), .GAP_SCLKS(GAP_SCLKS)) u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .done(done),
  .inReady(inReady), .halfDiv(halfDiv)
);

// File: tb/test_cache_load_seq.sv
`timescale 1ns/1ps
module test_cache_load_seq;
  localparam int LEN_W = 12;
  localparam int DIV_W = 8;
  localparam int MAXD  = 1020;

  logic             clk = 1'b0;
  logic             rstN;
  logic             start;
  logic [LEN_W-1:0] pageLen;
  logic             quadSel;
  logic [DIV_W-1:0] halfDiv;
  logic [7:0]       inData;
  logic             inValid;
  logic             inReady;
  logic             sclk;
  logic             csN;
  logic [3:0]       io;
  logic             done;

  cache_load_seq i_cache_load_seq (
    .clk(clk), .rstN(rstN), .start(start), .pageLen(pageLen), .quadSel(quadSel),
    .halfDiv(halfDiv), .inData(inData), .inValid(inValid), .inReady(inReady),
    .sclk(sclk), .csN(csN), .io(io), .done(done)
  );

  always #5 clk = ~clk;

  int nChecks = 0;
  int nFails  = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int i, input int s);
    return 8'((i * 29 + s * 53 + (i >> 5)) & 255);
  endfunction

  // Stream source
  int srcIdx = 0, srcLen = 0, seed = 0, cyc = 0;
  bit srcStall = 0;
  initial begin
    bit fire;
    inValid = 1'b0;
    inData  = 8'h00;
    forever begin
      @(negedge clk);
      fire = inValid && inReady;
      @(posedge clk);
      #1;
      if (fire) srcIdx++;
      cyc++;
      inValid = (srcIdx < srcLen) && !(srcStall && ((cyc % 5) < 2));
      inData  = pat(srcIdx, seed);
    end
  end

  // Serial monitor with a cache model
  bit          monOn = 0, monQuad = 0;
  logic [7:0]  rxMem [4096];
  logic [31:0] hdrSh;
  logic [7:0]  dSh;
  int          bitPos, nib, dCnt, nChunks, gapBad, hiBad, edgeBad, doneCnt, doneCsBad;
  int          chunkOp [8], chunkAddr [8], chunkCnt [8];
  longint      lastRise, hiStart;

  always @(negedge csN) if (monOn) begin
    if ($time - lastRise < 40 * (longint'(halfDiv) + 1)) gapBad++;
    if (sclk) edgeBad++;
    bitPos = 0; nib = 0; dCnt = 0; hdrSh = '0; dSh = '0;
  end

  always @(posedge csN) if (monOn) begin
    lastRise = $time;
    if (sclk) edgeBad++;
    if (nChunks < 8) begin
      chunkOp[nChunks]   = int'(hdrSh[31:24]);
      chunkAddr[nChunks] = int'(hdrSh[23:0]);
      chunkCnt[nChunks]  = dCnt;
    end
    nChunks++;
  end

  always @(posedge sclk) if (monOn) begin
    hiStart = $time;
    if (csN) edgeBad++;
    else if (bitPos < 32) begin
      hdrSh = {hdrSh[30:0], io[0]};
      bitPos++;
      if (bitPos == 32 && (hdrSh[31:24] == 8'h02 || hdrSh[31:24] == 8'h32))
        for (int k = 0; k < 4096; k++) rxMem[k] = 8'hEE;
    end else begin
      if (monQuad) dSh = {dSh[3:0], io};
      else         dSh = {dSh[6:0], io[0]};
      nib++;
      if (nib == (monQuad ? 2 : 8)) begin
        if (int'(hdrSh[23:0]) + dCnt < 4096) rxMem[int'(hdrSh[23:0]) + dCnt] = dSh;
        dCnt++;
        nib = 0;
      end
    end
  end

  always @(negedge sclk) if (monOn && hiStart >= 0) begin
    if ($time - hiStart != 10 * (longint'(halfDiv) + 1)) hiBad++;
  end

  always @(negedge clk) if (monOn && done) begin
    doneCnt++;
    if (csN !== 1'b1) doneCsBad++;
  end

  task automatic armMonitor(input bit quad);
    for (int k = 0; k < 4096; k++) rxMem[k] = 8'hEE;
    monQuad = quad; nChunks = 0; gapBad = 0; hiBad = 0; edgeBad = 0;
    doneCnt = 0; doneCsBad = 0; lastRise = -1000000; hiStart = -1;
    monOn = 1;
  endtask

  task automatic runPage(input int len, input bit quad, input bit stall,
                         input int div, input bit busyStart, input int sd);
    int rem, exp, bad, firstBad, guard;
    @(negedge clk);
    halfDiv = DIV_W'(div);
    armMonitor(quad);
    seed = sd; srcStall = stall; srcIdx = 0; srcLen = len;
    pageLen = LEN_W'(len); quadSel = quad; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (busyStart) begin
      repeat (200) @(negedge clk);
      pageLen = LEN_W'(5); quadSel = !quad; start = 1'b1;   // R12 stimulus
      @(negedge clk);
      start = 1'b0;
    end
    guard = 0;
    while (doneCnt == 0 && guard < 90000) begin @(negedge clk); guard++; end
    repeat (100) @(negedge clk);
    check(doneCnt == 1, "R9 one done pulse", doneCnt, 1);
    check(doneCsBad == 0, "R9 csN high at done", doneCsBad, 0);
    exp = (len + MAXD - 1) / MAXD;
    check(nChunks == exp, busyStart ? "R12 chunk count unchanged" : "R2 chunk count", nChunks, exp);
    rem = len;
    for (int c = 0; c < exp && c < 8; c++) begin
      int sz = (rem > MAXD) ? MAXD : rem;
      int op = (c == 0) ? (quad ? 8'h32 : 8'h02) : (quad ? 8'h34 : 8'h84);
      check(chunkCnt[c] == sz, "R2 chunk size", chunkCnt[c], sz);
      check(chunkOp[c] == op, (c == 0) ? "R3 first opcode" : "R4 later opcode", chunkOp[c], op);
      check(chunkAddr[c] == len - rem, "R5 column address", chunkAddr[c], len - rem);
      rem -= sz;
    end
    bad = 0; firstBad = -1;
    for (int i = 0; i < len; i++) if (rxMem[i] !== pat(i, sd)) begin
      bad++;
      if (firstBad < 0) firstBad = i;
    end
    check(bad == 0, quad ? "R6 quad data in cache" : "R6 single data in cache", bad, 0);
    if (bad != 0) $display("  first bad byte index %0d", firstBad);
    check(srcIdx == len, stall ? "R10 bytes taken under stall" : "R10 bytes taken", srcIdx, len);
    check(gapBad == 0, "R8 chip select gap", gapBad, 0);
    check(hiBad == 0, "R13 sclk high time", hiBad, 0);
    check(edgeBad == 0, "R7 sclk low around csN", edgeBad, 0);
    monOn = 0;
  endtask

  task automatic zeroLength();
    @(negedge clk);
    armMonitor(1'b0);
    srcIdx = 0; srcLen = 0;
    pageLen = '0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    check(doneCnt == 1, "R11 done for empty page", doneCnt, 1);
    repeat (50) @(negedge clk);
    check(nChunks == 0 && csN === 1'b1, "R11 no transaction", nChunks, 0);
    monOn = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    rstN = 1'b0; start = 1'b0; pageLen = '0; quadSel = 1'b0; halfDiv = '0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(csN === 1'b1, "R1 csN after reset", csN, 1);
    check(sclk === 1'b0, "R1 sclk after reset", sclk, 0);
    check(done === 1'b0, "R1 done after reset", done, 0);
    check(inReady === 1'b0, "R1 inReady after reset", inReady, 0);

    runPage(2112, 1'b1, 1'b0, 0, 1'b0, 1);  // 1020/1020/72 four-line
    runPage(2112, 1'b0, 1'b1, 0, 1'b0, 2);  // single-line with stalls
    runPage(1020, 1'b1, 1'b0, 2, 1'b0, 3);  // exactly one full chunk
    runPage(1021, 1'b0, 1'b0, 0, 1'b0, 4);  // one byte into a second chunk
    runPage(1500, 1'b1, 1'b1, 1, 1'b1, 5);  // start during page ignored
    zeroLength();

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule